// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel with a memory-mapped master port. Software fills a small register set: a peripheral-side address, a memory-side address, a unit count and a control word. The control word holds the enable, the direction, the circular and self-triggered options, and a width and increment choice for each side. When the channel is enabled, it moves one data unit at a time. Each unit is one read from the source side at that side's width, followed by one write to the destination side at that side's width.

In request-driven mode, each unit waits for a single-cycle pulse on the request input. In self-triggered mode, the units run back to back after enabling. When the count runs out, a sticky completion flag is raised. A normal channel then goes idle. A circular channel restores its count and both addresses and keeps going.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `bus_req`, `chan_on`, `tc_flag` and `units_left` are all zero.
- R2: When control bit 3 is set, units start without any request once the channel is enabled. During a beat, `bus_addr`, `bus_we` and `bus_size` stay stable until `bus_ack` is seen.
- R3: When control bit 3 is clear, each unit needs one `xfer_req` pulse, and there is no bus traffic without one. A pulse that arrives while a unit is in flight is held (one deep) and starts the next unit.
- R4: Control bit 1 sets the direction. With 0, the peripheral-side address is read and the memory-side address is written. With 1, the memory side is read and the peripheral side is written.
- R5: Each side has a size code: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. The code goes out on `bus_size` for that side's beats. Data is right-aligned in the 32-bit word. The write carries the read value cut to the narrower of the two widths, with zeros above that width.
- R6: Each side has its own increment enable: control bit 4 for the peripheral side and bit 5 for the memory side. An enabled side advances by 1, 2 or 4 bytes after each unit, according to its size code. A disabled side reuses the same address.
- R7: On enable, `units_left` takes the programmed count. It drops by one after each unit's write is acknowledged.
- R8: In normal mode (control bit 2 clear), the last unit brings `units_left` to 0 and sets `tc_flag`, and no further beats are issued. With a count of 0, the channel issues no beats at all.
- R9: In circular mode (control bit 2 set), the last unit sets `tc_flag`, reloads `units_left` with the programmed count, returns both addresses to their programmed bases, and transfers continue.
- R10: `tc_flag` stays set until a control write with bit 10 set. That clear works whether the channel is on or off.
- R11: While the channel is on, writes to register 1 (peripheral address), register 2 (memory address) and register 3 (count) are ignored, as are control bits 1 to 9. Control bit 0 (enable) can be written at any time.
- R12: Registers are chosen with `cfg_sel` and written with a one-cycle `cfg_we`. Control (0) has this layout: bit 0 enable, 1 direction, 2 circular, 3 self-triggered, 4 and 5 increments, 7:6 peripheral size, 9:8 memory size, 10 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| xfer_req | input | 1 | Peripheral request pulse |
| bus_req | output | 1 | Beat valid |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | ADDR_W | Byte address of the beat |
| bus_size | output | 2 | Size code of the beat |
| bus_wdata | output | 32 | Right-aligned write data |
| bus_rdata | input | 32 | Right-aligned read data |
| bus_ack | input | 1 | Beat completion |
| chan_on | output | 1 | Channel enabled |
| tc_flag | output | 1 | Sticky transfer-complete flag |
| units_left | output | CNT_W | Units still to move |

## Verification
The main function is tried with each pairing of narrow and wide source and destination widths. The read model always returns a full 32-bit word, so a missing cut to the narrower width shows up as stray upper bytes. Runs are made with each increment enable on and off, and with each direction, which separates a wrong stride or a swapped side from a correct one. Request-driven runs with no pulses, spaced pulses and back-to-back pulses separate self-triggering from request counting. Circular runs longer than the count, together with register writes while the channel is on, show that the reload happens and that the count is protected from those writes.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int REG_CTL   = 0;
  localparam int REG_PADDR = 1;
  localparam int REG_MADDR = 2;
  localparam int REG_COUNT = 3;

  localparam int CTL_EN    = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_CIRC  = 2;
  localparam int CTL_M2M   = 3;
  localparam int CTL_PINC  = 4;
  localparam int CTL_MINC  = 5;
  localparam int CTL_PSZ   = 6;
  localparam int CTL_MSZ   = 8;
  localparam int CTL_TCCLR = 10;

  localparam int SIDE_PER = 0;
  localparam int SIDE_MEM = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic            dir;
    logic            circ;
    logic            m2m;
    logic [1:0]      inc;
    logic [1:0][1:0] sz;
  } chan_cfg_t;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] adapt_width(input logic [31:0] data,
                                              input logic [1:0]  src_sz,
                                              input logic [1:0]  dst_sz);
    return data & width_mask(src_sz) & width_mask(dst_sz);
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  output chan_cfg_t         cfg,
  output logic              en,
  output logic [ADDR_W-1:0] per_base,
  output logic [ADDR_W-1:0] mem_base,
  output logic [CNT_W-1:0]  cnt_prog,
  output logic              load_evt,
  output logic              tc_clr
);

  logic ctl_wr, arm, open_wr;

  assign ctl_wr  = we && (sel == 2'(REG_CTL));
  assign open_wr = we && !en;
  assign arm     = ctl_wr && wdata[CTL_EN] && !en;
  assign tc_clr  = ctl_wr && wdata[CTL_TCCLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      cfg      <= '0;
      per_base <= '0;
      mem_base <= '0;
      cnt_prog <= '0;
      load_evt <= 1'b0;
    end else begin
      load_evt <= arm;
      if (ctl_wr) en <= wdata[CTL_EN];
      if (ctl_wr && !en) begin
        cfg.dir  <= wdata[CTL_DIR];
        cfg.circ <= wdata[CTL_CIRC];
        cfg.m2m  <= wdata[CTL_M2M];
        cfg.inc  <= {wdata[CTL_MINC], wdata[CTL_PINC]};
        cfg.sz   <= {wdata[CTL_MSZ+1:CTL_MSZ], wdata[CTL_PSZ+1:CTL_PSZ]};
      end
      if (open_wr && sel == 2'(REG_PADDR)) per_base <= wdata[ADDR_W-1:0];
      if (open_wr && sel == 2'(REG_MADDR)) mem_base <= wdata[ADDR_W-1:0];
      if (open_wr && sel == 2'(REG_COUNT)) cnt_prog <= wdata[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wrap,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        sz,
  input  logic              inc,
  output logic [ADDR_W-1:0] cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cur <= '0;
    else if (load || wrap)  cur <= base;
    else if (adv && inc)    cur <= cur + ADDR_W'(unit_bytes(sz));
  end

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             live,
  input  logic             m2m,
  input  logic             circ,
  input  logic             req_in,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_prog,
  input  logic [1:0]       src_sz,
  input  logic [1:0]       dst_sz,
  input  logic             bus_ack,
  input  logic [31:0]      bus_rdata,
  output logic             rd_phase,
  output logic             wr_phase,
  output logic [CNT_W-1:0] units_left,
  output logic             unit_done,
  output logic             last_unit,
  output logic             wrap_evt,
  output logic [31:0]      hold_data
);

  xfer_state_e state;
  logic        pend, start;

  assign start     = (state == ST_IDLE) && live && (units_left != '0) && (m2m || pend);
  assign rd_phase  = (state == ST_READ);
  assign wr_phase  = (state == ST_WRITE);
  assign unit_done = wr_phase && bus_ack;
  assign last_unit = unit_done && (units_left == CNT_W'(1));
  assign wrap_evt  = last_unit && circ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pend       <= 1'b0;
      units_left <= '0;
      hold_data  <= '0;
    end else begin
      if (!en)                pend <= 1'b0;
      else if (start && !m2m) pend <= req_in;
      else if (req_in)        pend <= 1'b1;

      if (load)             units_left <= cnt_prog;
      else if (wrap_evt)    units_left <= cnt_prog;
      else if (unit_done)   units_left <= units_left - CNT_W'(1);

      case (state)
        ST_IDLE:  if (start) state <= ST_READ;
        ST_READ:  if (bus_ack) begin
                    hold_data <= adapt_width(bus_rdata, src_sz, dst_sz);
                    state     <= ST_WRITE;
                  end
        ST_WRITE: if (bus_ack) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              xfer_req,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic              chan_on,
  output logic              tc_flag,
  output logic [CNT_W-1:0]  units_left
);

  localparam int NSIDE = 2;

  chan_cfg_t                     cfg;
  logic                          load_evt, tc_clr, live;
  logic                          rd_phase, wr_phase, unit_done, last_unit, wrap_evt;
  logic [ADDR_W-1:0]             per_base, mem_base;
  logic [CNT_W-1:0]              cnt_prog;
  logic [31:0]                   hold_data;
  logic [NSIDE-1:0][ADDR_W-1:0]  side_base, side_cur;
  logic [ADDR_W-1:0]             src_addr, dst_addr;
  logic [1:0]                    src_sz, dst_sz;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .cfg(cfg), .en(chan_on), .per_base(per_base), .mem_base(mem_base),
    .cnt_prog(cnt_prog), .load_evt(load_evt), .tc_clr(tc_clr)
  );

  assign side_base[SIDE_PER] = per_base;
  assign side_base[SIDE_MEM] = mem_base;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .clk(clk), .rst_n(rst_n), .load(load_evt), .wrap(wrap_evt), .adv(unit_done),
      .base(side_base[s]), .sz(cfg.sz[s]), .inc(cfg.inc[s]), .cur(side_cur[s])
    );
  end

  assign src_addr = cfg.dir ? side_cur[SIDE_MEM] : side_cur[SIDE_PER];
  assign dst_addr = cfg.dir ? side_cur[SIDE_PER] : side_cur[SIDE_MEM];
  assign src_sz   = cfg.dir ? cfg.sz[SIDE_MEM]   : cfg.sz[SIDE_PER];
  assign dst_sz   = cfg.dir ? cfg.sz[SIDE_PER]   : cfg.sz[SIDE_MEM];
  assign live     = chan_on && !load_evt;

  dma_xfer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(chan_on), .live(live), .m2m(cfg.m2m),
    .circ(cfg.circ), .req_in(xfer_req), .load(load_evt), .cnt_prog(cnt_prog),
    .src_sz(src_sz), .dst_sz(dst_sz), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .rd_phase(rd_phase), .wr_phase(wr_phase), .units_left(units_left),
    .unit_done(unit_done), .last_unit(last_unit), .wrap_evt(wrap_evt),
    .hold_data(hold_data)
  );

  assign bus_req   = rd_phase || wr_phase;
  assign bus_we    = wr_phase;
  assign bus_addr  = wr_phase ? dst_addr : src_addr;
  assign bus_size  = wr_phase ? dst_sz : src_sz;
  assign bus_wdata = hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tc_flag <= 1'b0;
    else if (last_unit) tc_flag <= 1'b1;
    else if (tc_clr)    tc_flag <= 1'b0;
  end

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [31:0]       bus_wdata,
  input logic              chan_on,
  input logic              tc_flag,
  input logic [CNT_W-1:0]  units_left,
  input logic              unit_done,
  input logic              load_evt
);

  assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));

  assert_narrow_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_size == 2'd0 |-> bus_wdata[31:8] == 24'd0);

  assert_half_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_size == 2'd1 |-> bus_wdata[31:16] == 16'd0);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done && units_left != CNT_W'(1) |=> units_left == $past(units_left) - CNT_W'(1));

  assert_idle_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    units_left == '0 |-> !bus_req);

  assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(unit_done));

  assert_count_guard_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chan_on && !unit_done && !load_evt |=> $stable(units_left));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .chan_on(chan_on),
  .tc_flag(tc_flag), .units_left(units_left), .unit_done(unit_done), .load_evt(load_evt)
);

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        xfer_req = 1'b0;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;
  logic [31:0] bus_rdata = 32'd0;
  logic        bus_ack = 1'b0;
  logic        chan_on, tc_flag;
  logic [15:0] units_left;

  dma_chan_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .xfer_req(xfer_req), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .chan_on(chan_on), .tc_flag(tc_flag), .units_left(units_left)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  bit  reported = 0;
  logic [7:0] mem [0:255];

  bit s_dir, s_circ, s_m2m, s_pinc, s_minc;
  int s_psz, s_msz, s_pb, s_mb, s_cnt;
  int wr_seen = 0;
  int rd_busy = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  endtask

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic int stride(input int sz, input bit inc);
    return inc ? nbytes(sz) : 0;
  endfunction

  function automatic int exp_addr(input bit want_src, input int k);
    bit use_mem;
    int i;
    use_mem = want_src ? s_dir : !s_dir;
    i = (s_cnt == 0) ? 0 : k % s_cnt;
    return use_mem ? s_mb + i * stride(s_msz, s_minc) : s_pb + i * stride(s_psz, s_pinc);
  endfunction

  function automatic int src_sz();
    return s_dir ? s_msz : s_psz;
  endfunction

  function automatic int dst_sz();
    return s_dir ? s_psz : s_msz;
  endfunction

  function automatic logic [31:0] exp_value(input int a);
    logic [31:0] v = 32'd0;
    int n = nbytes(src_sz()) < nbytes(dst_sz()) ? nbytes(src_sz()) : nbytes(dst_sz());
    for (int j = 0; j < n; j++) v[8*j +: 8] = mem[(a + j) & 255];
    return v;
  endfunction

  function automatic logic [31:0] ctl(input bit en, input bit dir, input bit circ, input bit m2m,
                                      input bit pinc, input bit minc, input int psz, input int msz,
                                      input bit clr);
    logic [31:0] w = 32'd0;
    w[0] = en; w[1] = dir; w[2] = circ; w[3] = m2m; w[4] = pinc; w[5] = minc;
    w[7:6] = 2'(psz); w[9:8] = 2'(msz); w[10] = clr;
    return w;
  endfunction

  // bus responder: random wait, full-word reads, checks against bench model
  initial begin : responder
    int wait_left = -1;
    void'($urandom(32'd20240611));
    forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (wait_left < 0) wait_left = $urandom_range(0, 2);
        if (wait_left == 0) begin
          wait_left = -1;
          if (!bus_we) begin
            chk(bus_addr == 32'(exp_addr(1, wr_seen)), "R4 R6 read address", bus_addr, 32'(exp_addr(1, wr_seen)));
            chk(bus_size == 2'(src_sz()), "R5 read size", 32'(bus_size), 32'(src_sz()));
            bus_rdata = {mem[(bus_addr + 3) & 255], mem[(bus_addr + 2) & 255],
                         mem[(bus_addr + 1) & 255], mem[bus_addr & 255]};
          end else begin
            chk(bus_addr == 32'(exp_addr(0, wr_seen)), "R4 R6 write address", bus_addr, 32'(exp_addr(0, wr_seen)));
            chk(bus_size == 2'(dst_sz()), "R5 write size", 32'(bus_size), 32'(dst_sz()));
            chk(bus_wdata == exp_value(exp_addr(1, wr_seen)), "R5 write data", bus_wdata, exp_value(exp_addr(1, wr_seen)));
            for (int j = 0; j < nbytes(dst_sz()); j++) mem[(bus_addr + j) & 255] = bus_wdata[8*j +: 8];
            wr_seen++;
          end
          bus_ack = 1'b1;
        end else wait_left--;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    summary();
  end

  task automatic reg_wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
  endtask

  task automatic wait_writes(input int n, input string tag);
    int t = 0;
    while (wr_seen < n && t < 3000) begin @(negedge clk); t++; end
    chk(wr_seen == n, tag, 32'(wr_seen), 32'(n));
  endtask

  task automatic setup(input bit dir, input bit circ, input bit m2m, input bit pinc, input bit minc,
                       input int psz, input int msz, input int pb, input int mb, input int cnt);
    reg_wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 1));
    reg_wr(1, 32'(pb)); reg_wr(2, 32'(mb)); reg_wr(3, 32'(cnt));
    s_dir = dir; s_circ = circ; s_m2m = m2m; s_pinc = pinc; s_minc = minc;
    s_psz = psz; s_msz = msz; s_pb = pb; s_mb = mb; s_cnt = cnt;
    wr_seen = 0;
    reg_wr(0, ctl(1, dir, circ, m2m, pinc, minc, psz, msz, 0));
  endtask

  task automatic run_m2m(input bit dir, input bit pinc, input bit minc, input int psz, input int msz,
                         input int pb, input int mb, input int cnt);
    setup(dir, 0, 1, pinc, minc, psz, msz, pb, mb, cnt);
    wait_writes(cnt, "R2 self-triggered unit count");
    repeat (4) @(negedge clk);
    chk(wr_seen == cnt, "R8 no extra units", 32'(wr_seen), 32'(cnt));
    chk(tc_flag == 1'b1, "R8 flag after last unit", 32'(tc_flag), 32'd1);
    chk(units_left == 16'd0, "R7 count drained", 32'(units_left), 32'd0);
    chk(bus_req == 1'b0, "R8 bus quiet", 32'(bus_req), 32'd0);
  endtask

  initial begin : main
    int busy_cycles;
    for (int a = 0; a < 256; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 3) ^ 8'h5A);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_req == 0 && chan_on == 0 && tc_flag == 0 && units_left == 0, "R1 reset outputs",
        {28'd0, bus_req, chan_on, tc_flag, |units_left}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_req == 0 && chan_on == 0, "R1 idle after reset", {30'd0, bus_req, chan_on}, 32'd0);

    // directed width pairings (R5), directions (R4), strides (R6)
    run_m2m(0, 1, 1, 0, 0, 16, 144, 4);
    // R10 flag sticky, then cleared
    repeat (10) @(negedge clk);
    chk(tc_flag == 1'b1, "R10 flag sticky", 32'(tc_flag), 32'd1);
    reg_wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 1));
    @(negedge clk);
    chk(tc_flag == 1'b0, "R10 flag cleared", 32'(tc_flag), 32'd0);

    run_m2m(0, 1, 1, 2, 0, 20, 150, 3);
    run_m2m(0, 1, 1, 0, 2, 24, 160, 3);
    run_m2m(1, 1, 0, 1, 2, 40, 176, 4);
    run_m2m(1, 0, 1, 3, 1, 44, 180, 3);
    run_m2m(0, 0, 0, 1, 1, 30, 200, 2);

    // R8 zero count: no traffic
    setup(0, 0, 1, 1, 1, 0, 0, 16, 144, 0);
    busy_cycles = 0;
    repeat (20) begin @(negedge clk); if (bus_req) busy_cycles++; end
    chk(busy_cycles == 0, "R8 zero count quiet", 32'(busy_cycles), 32'd0);
    chk(tc_flag == 1'b0, "R8 zero count no flag", 32'(tc_flag), 32'd0);

    // R3 request-driven mode
    setup(0, 0, 0, 1, 1, 1, 1, 16, 144, 3);
    busy_cycles = 0;
    repeat (20) begin @(negedge clk); if (bus_req) busy_cycles++; end
    chk(busy_cycles == 0, "R3 no request no traffic", 32'(busy_cycles), 32'd0);
    chk(units_left == 16'd3, "R7 count loaded on enable", 32'(units_left), 32'd3);
    pulse(); pulse();
    wait_writes(2, "R3 queued pulse");
    repeat (8) @(negedge clk);
    chk(wr_seen == 2, "R3 one unit per pulse", 32'(wr_seen), 32'd2);
    chk(units_left == 16'd1, "R7 count after two units", 32'(units_left), 32'd1);
    chk(tc_flag == 1'b0, "R8 no early flag", 32'(tc_flag), 32'd0);
    pulse();
    wait_writes(3, "R3 third pulse");
    repeat (3) @(negedge clk);
    chk(tc_flag == 1'b1, "R8 flag in request mode", 32'(tc_flag), 32'd1);

    // R9 circular with reload, R11 ignored writes, R10 clear while on
    setup(1, 1, 0, 1, 1, 2, 0, 48, 190, 2);
    for (int u = 1; u <= 5; u++) begin
      pulse();
      wait_writes(u, "R9 circular unit");
      repeat (3) @(negedge clk);
    end
    chk(units_left == 16'd1, "R9 count reloaded", 32'(units_left), 32'd1);
    chk(tc_flag == 1'b1, "R9 flag on wrap", 32'(tc_flag), 32'd1);
    chk(chan_on == 1'b1, "R9 still running", 32'(chan_on), 32'd1);
    reg_wr(0, ctl(1, 0, 0, 1, 0, 0, 0, 0, 1));
    @(negedge clk);
    chk(tc_flag == 1'b0, "R10 clear while on", 32'(tc_flag), 32'd0);
    reg_wr(3, 32'd9);
    reg_wr(1, 32'd112);
    @(negedge clk);
    chk(units_left == 16'd1, "R11 count write ignored", 32'(units_left), 32'd1);
    busy_cycles = 0;
    repeat (10) begin @(negedge clk); if (bus_req) busy_cycles++; end
    chk(busy_cycles == 0, "R11 mode write ignored", 32'(busy_cycles), 32'd0);
    pulse();
    wait_writes(6, "R11 unit after ignored writes");
    repeat (3) @(negedge clk);
    chk(units_left == 16'd2, "R11 reload uses old count", 32'(units_left), 32'd2);
    reg_wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0, 1));
    @(negedge clk);
    chk(chan_on == 1'b0, "R12 enable bit clears", 32'(chan_on), 32'd0);

    // constrained random self-triggered runs
    for (int r = 0; r < 10; r++) begin
      run_m2m(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              $urandom_range(0, 2), $urandom_range(0, 2),
              16 + $urandom_range(0, 40), 144 + $urandom_range(0, 40), $urandom_range(1, 6));
    end

    summary();
  end

endmodule